// File: doc/BRIEF.md
# Speculative Separable Switch Allocator

This block decides, every cycle, which input virtual channels of a router may cross the switch and which output port each of them gets. The router has P input ports, P output ports and V virtual channels on each input. Each virtual channel presents a request flag, the output port it wants and a flag marking the request as speculative. A speculative request comes from a head flit whose virtual-channel allocation is still being resolved in the same cycle. Requests from body and tail flits are always presented as non-speculative, because those flits already hold a virtual channel.

Two separable allocators evaluate side by side, one for each request class. In each allocator a round-robin V:1 arbiter per input picks one channel and forwards that channel's port request. A round-robin P:1 arbiter per output then picks one of the forwarded inputs. The two results are merged: a non-speculative grant always holds. A speculative grant is dropped if its output or its input already has a non-speculative grant, or if the virtual-channel allocation for that channel failed this cycle. A dropped speculative grant is simply wasted, and the flit asks again. Round-robin pointers move only for grants that survive the merge. The final grants are registered and appear one cycle after the request as a per-input one-hot channel grant and a per-output one-hot crossbar select.

Top module: `saSwitchAlloc`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every bit of `grantVc` and `xbarSel` is 0.
- R2: `grantVc[i*V+v]` is set only if channel v of input i requested in the previous cycle, and at most one channel per input is granted. When it is set, `xbarSel[o*P+i]` is set for the output o that the channel requested, and no other output selects input i.
- R3: Each output selects at most one input (`xbarSel[o*P +: P]` is one-hot or zero), and each input is selected by at most one output.
- R4: Within one input and one request class, channels are served round-robin. After channel v wins a grant that survives, channel (v+1) mod V has the highest priority the next time that input's arbiter for that class picks.
- R5: At each output and in each request class, inputs are served round-robin. After input i wins a surviving grant, input (i+1) mod P has the highest priority. After reset, channel 0 and input 0 have the highest priority.
- R6: When a non-speculative winner and a speculative winner exist for the same output, only the non-speculative one is granted.
- R7: A speculative grant to an input that also received a non-speculative grant in the same cycle is dropped.
- R8: A speculative grant for a channel whose `vaOk` bit is 0 in the same cycle is dropped. The channel gets no grant that cycle, and it may be granted when it requests again.
- R9: Arbiter pointers advance only for grants that survive the merge. A dropped speculative grant leaves both pointers of its allocator unchanged.
- R10: Grants for a request appear on the outputs one clock after it is presented. A request whose port field (`reqPort[k*PW +: PW]`, PW = ceil(log2 P)) is P or larger is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | P*V | Request flag per virtual channel, index i*V+v |
| reqPort | input | P*V*PW | Requested output port per channel, field k at k*PW |
| reqSpec | input | P*V | 1 marks the channel's request as speculative |
| vaOk | input | P*V | 1 when the channel's virtual-channel allocation succeeds this cycle |
| grantVc | output | P*V | Registered per-input one-hot channel grant |
| xbarSel | output | P*P | Registered per-output one-hot crossbar select, bit o*P+i |

## Verification
The bench uses the default P=5 and V=4, so the port field is three bits wide. The codes 5 to 7 are then available to exercise the ignored-port rule. Five inputs contending for one output make a full pointer wrap at stage two, and four channels on one input make a full wrap at stage one. With both request classes active and `vaOk` randomly low, every merge case occurs: a speculative grant lost at the output, lost at the input, or wasted by a failed channel allocation. A bench model that tracks its own pointers checks every cycle.

// File: rtl/saPkg.sv
package saPkg;
  localparam int MAX_REQ = 32;

  // Round-robin pick: first requester at or after ptr, wrapping at n; -1 if none.
  function automatic int rrPick(input logic [MAX_REQ-1:0] req, input int n, input int ptr);
    int idx;
    rrPick = -1;
    for (int k = 0; k < MAX_REQ; k++) begin
      if (k < n) begin
        idx = ptr + k;
        if (idx >= n) idx = idx - n;
        if (rrPick < 0 && req[idx]) rrPick = idx;
      end
    end
  endfunction
endpackage

// File: rtl/saRrArb.sv
module saRrArb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] req,
  input  logic [N-1:0] updOh,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr;
  logic [IW-1:0] ptrNext;
  logic [saPkg::MAX_REQ-1:0] reqWide;
  int winIdx;

  always_comb begin
    reqWide = '0;
    reqWide[N-1:0] = req;
    winIdx = saPkg::rrPick(reqWide, N, int'(ptr));
    for (int k = 0; k < N; k++) gnt[k] = (winIdx == k);
  end

  always_comb begin
    ptrNext = ptr;
    for (int k = 0; k < N; k++) begin
      if (updOh[k]) ptrNext = (k == N - 1) ? '0 : IW'(k + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ptr <= '0;
    else       ptr <= ptrNext;
  end

  a_r4_grant_in_req: assert property (@(posedge clk) disable iff (!rstN)
    (gnt & ~req) == '0);
  a_r4_grant_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gnt));
  a_r4_work_conserving: assert property (@(posedge clk) disable iff (!rstN)
    (|req) |-> (|gnt));
endmodule

// File: rtl/saSepAlloc.sv
module saSepAlloc #(
  parameter int P  = 5,
  parameter int V  = 4,
  parameter int PW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [P*V-1:0]    req,
  input  logic [P*V*PW-1:0] reqPort,
  input  logic [P*V-1:0]    updVc,
  input  logic [P*P-1:0]    updSel,
  output logic [P*V-1:0]    vcWin,
  output logic [P*P-1:0]    outSel
);
  logic [P-1:0]    fwdValid;
  logic [PW-1:0]   fwdPort [P];
  logic [P*P-1:0]  stage2Req;

  for (genvar i = 0; i < P; i++) begin : g_in
    saRrArb #(.N(V)) u_vcArb (
      .clk   (clk),
      .rstN  (rstN),
      .req   (req[i*V +: V]),
      .updOh (updVc[i*V +: V]),
      .gnt   (vcWin[i*V +: V])
    );

    always_comb begin
      fwdValid[i] = |vcWin[i*V +: V];
      fwdPort[i]  = '0;
      for (int v = 0; v < V; v++) begin
        if (vcWin[i*V+v]) fwdPort[i] = reqPort[(i*V+v)*PW +: PW];
      end
    end
  end

  for (genvar o = 0; o < P; o++) begin : g_out
    for (genvar i = 0; i < P; i++) begin : g_req
      assign stage2Req[o*P+i] = fwdValid[i] && (fwdPort[i] == PW'(o));
    end

    saRrArb #(.N(P)) u_portArb (
      .clk   (clk),
      .rstN  (rstN),
      .req   (stage2Req[o*P +: P]),
      .updOh (updSel[o*P +: P]),
      .gnt   (outSel[o*P +: P])
    );
  end
endmodule

// File: rtl/saCtrl.sv
module saCtrl #(
  parameter int P  = 5,
  parameter int V  = 4,
  parameter int PW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [P*V-1:0]    reqValid,
  input  logic [P*V*PW-1:0] reqPort,
  input  logic [P*V-1:0]    reqSpec,
  input  logic [P*V-1:0]    vaOk,
  output logic [P*V-1:0]    finVc,
  output logic [P*P-1:0]    finSel
);
  logic [P*V-1:0] portOk;
  logic [P*V-1:0] nsReq, spReq;
  logic [P*V-1:0] nsVcWin, spVcWin;
  logic [P*P-1:0] nsSel, spSel;
  logic [P*P-1:0] spKeep;
  logic [P*V-1:0] nsVcFin, spVcFin;
  logic [P-1:0]   inNs, spInKeep, spVaHit, outNs;
  logic [P-1:0]   colSel [P];

  for (genvar k = 0; k < P*V; k++) begin : g_mask
    assign portOk[k] = reqPort[k*PW +: PW] < PW'(P);
    assign nsReq[k]  = reqValid[k] & portOk[k] & ~reqSpec[k];
    assign spReq[k]  = reqValid[k] & portOk[k] &  reqSpec[k];
  end

  saSepAlloc #(.P(P), .V(V), .PW(PW)) u_nsAlloc (
    .clk     (clk),
    .rstN    (rstN),
    .req     (nsReq),
    .reqPort (reqPort),
    .updVc   (nsVcFin),
    .updSel  (nsSel),
    .vcWin   (nsVcWin),
    .outSel  (nsSel)
  );

  saSepAlloc #(.P(P), .V(V), .PW(PW)) u_spAlloc (
    .clk     (clk),
    .rstN    (rstN),
    .req     (spReq),
    .reqPort (reqPort),
    .updVc   (spVcFin),
    .updSel  (spKeep),
    .vcWin   (spVcWin),
    .outSel  (spSel)
  );

  always_comb begin
    for (int i = 0; i < P; i++) begin
      inNs[i]    = 1'b0;
      spVaHit[i] = |(spVcWin[i*V +: V] & vaOk[i*V +: V]);
      for (int o = 0; o < P; o++) inNs[i] = inNs[i] | nsSel[o*P+i];
    end
    for (int o = 0; o < P; o++) begin
      outNs[o] = |nsSel[o*P +: P];
      for (int i = 0; i < P; i++)
        spKeep[o*P+i] = spSel[o*P+i] & ~outNs[o] & ~inNs[i] & spVaHit[i];
    end
    for (int i = 0; i < P; i++) begin
      spInKeep[i] = 1'b0;
      for (int o = 0; o < P; o++) spInKeep[i] = spInKeep[i] | spKeep[o*P+i];
      for (int v = 0; v < V; v++) begin
        nsVcFin[i*V+v] = nsVcWin[i*V+v] & inNs[i];
        spVcFin[i*V+v] = spVcWin[i*V+v] & spInKeep[i];
      end
    end
    finVc  = nsVcFin | spVcFin;
    finSel = nsSel | spKeep;
    for (int i = 0; i < P; i++)
      for (int o = 0; o < P; o++) colSel[i][o] = finSel[o*P+i];
  end

  for (genvar o = 0; o < P; o++) begin : g_chkOut
    a_r6_ns_wins_output: assert property (@(posedge clk) disable iff (!rstN)
      (|nsSel[o*P +: P]) |-> (finSel[o*P +: P] == nsSel[o*P +: P]));
    a_r3_out_onehot: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(finSel[o*P +: P]));
  end

  for (genvar i = 0; i < P; i++) begin : g_chkIn
    a_r7_ns_wins_input: assert property (@(posedge clk) disable iff (!rstN)
      inNs[i] |-> (finVc[i*V +: V] == nsVcWin[i*V +: V]));
    a_r3_in_once: assert property (@(posedge clk) disable iff (!rstN)
      $countones(colSel[i]) <= 1);
    a_r2_sel_matches_vc: assert property (@(posedge clk) disable iff (!rstN)
      (|colSel[i]) == (|finVc[i*V +: V]));
  end

  for (genvar k = 0; k < P*V; k++) begin : g_chkVc
    a_r8_spec_needs_va: assert property (@(posedge clk) disable iff (!rstN)
      (finVc[k] && reqSpec[k]) |-> vaOk[k]);
    a_r10_valid_port_only: assert property (@(posedge clk) disable iff (!rstN)
      finVc[k] |-> (reqValid[k] && reqPort[k*PW +: PW] < PW'(P)));
  end
endmodule

// File: rtl/saGrantRegs.sv
module saGrantRegs #(
  parameter int P = 5,
  parameter int V = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [P*V-1:0] finVc,
  input  logic [P*P-1:0] finSel,
  output logic [P*V-1:0] grantVc,
  output logic [P*P-1:0] xbarSel
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantVc <= '0;
      xbarSel <= '0;
    end else begin
      grantVc <= finVc;
      xbarSel <= finSel;
    end
  end

  for (genvar i = 0; i < P; i++) begin : g_chk
    a_r2_vc_onehot: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(grantVc[i*V +: V]));
  end
endmodule

// File: rtl/saSwitchAlloc.sv
module saSwitchAlloc #(
  parameter int P  = 5,
  parameter int V  = 4,
  localparam int PW = (P > 1) ? $clog2(P) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [P*V-1:0]    reqValid,
  input  logic [P*V*PW-1:0] reqPort,
  input  logic [P*V-1:0]    reqSpec,
  input  logic [P*V-1:0]    vaOk,
  output logic [P*V-1:0]    grantVc,
  output logic [P*P-1:0]    xbarSel
);
  logic [P*V-1:0] finVc;
  logic [P*P-1:0] finSel;

  saCtrl #(.P(P), .V(V), .PW(PW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqPort  (reqPort),
    .reqSpec  (reqSpec),
    .vaOk     (vaOk),
    .finVc    (finVc),
    .finSel   (finSel)
  );

  saGrantRegs #(.P(P), .V(V)) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .finVc   (finVc),
    .finSel  (finSel),
    .grantVc (grantVc),
    .xbarSel (xbarSel)
  );

  a_r10_granted_requested: assert property (@(posedge clk) disable iff (!rstN)
    (grantVc & ~$past(reqValid)) == '0);
endmodule

// File: tb/saSwitchAlloc_bench.sv
`timescale 1ns/1ps
module saSwitchAlloc_bench;
  localparam int P  = 5;
  localparam int V  = 4;
  localparam int PW = 3;
  localparam int NV = P*V;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NV-1:0]    reqValid = '0;
  logic [NV*PW-1:0] reqPort  = '0;
  logic [NV-1:0]    reqSpec  = '0;
  logic [NV-1:0]    vaOk     = '0;
  logic [NV-1:0]    grantVc;
  logic [P*P-1:0]   xbarSel;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state: class 0 = non-speculative, 1 = speculative
  int p1 [2][P];
  int p2 [2][P];
  int w1 [2][P];
  int w2 [2][P];
  logic [NV-1:0]  expVc;
  logic [P*P-1:0] expSel;

  always #2.5 clk = ~clk;

  saSwitchAlloc u_saSwitchAlloc (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPort(reqPort),
    .reqSpec(reqSpec), .vaOk(vaOk), .grantVc(grantVc), .xbarSel(xbarSel)
  );

  function automatic int portOf(int k);
    return int'(reqPort[k*PW +: PW]);
  endfunction

  task automatic pickClass(input int c);
    for (int i = 0; i < P; i++) begin
      w1[c][i] = -1;
      for (int s = 0; s < V; s++) begin
        int v = (p1[c][i] + s) % V;
        int k = i*V + v;
        if (w1[c][i] < 0 && reqValid[k] && portOf(k) < P && (reqSpec[k] == (c == 1))) w1[c][i] = v;
      end
    end
    for (int o = 0; o < P; o++) begin
      w2[c][o] = -1;
      for (int s = 0; s < P; s++) begin
        int i = (p2[c][o] + s) % P;
        if (w2[c][o] < 0 && w1[c][i] >= 0 && portOf(i*V + w1[c][i]) == o) w2[c][o] = i;
      end
    end
  endtask

  task automatic modelStep();
    bit inNs [P];
    pickClass(0);
    pickClass(1);
    expVc = '0;
    expSel = '0;
    for (int i = 0; i < P; i++) inNs[i] = 0;
    for (int o = 0; o < P; o++) begin
      if (w2[0][o] >= 0) begin
        int i = w2[0][o];
        expSel[o*P+i] = 1'b1;
        expVc[i*V + w1[0][i]] = 1'b1;
        inNs[i] = 1;
        p2[0][o] = (i + 1) % P;
        p1[0][i] = (w1[0][i] + 1) % V;
      end
    end
    for (int o = 0; o < P; o++) begin
      if (w2[1][o] >= 0) begin
        int i = w2[1][o];
        if (w2[0][o] < 0 && !inNs[i] && vaOk[i*V + w1[1][i]]) begin
          expSel[o*P+i] = 1'b1;
          expVc[i*V + w1[1][i]] = 1'b1;
          p2[1][o] = (i + 1) % P;
          p1[1][i] = (w1[1][i] + 1) % V;
        end
      end
    end
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs already set; compute model, clock, compare against model
  task automatic step(input string tag);
    modelStep();
    @(posedge clk);
    #1;
    check({tag, " grantVc"}, 64'(grantVc), 64'(expVc));
    check({tag, " xbarSel"}, 64'(xbarSel), 64'(expSel));
  endtask

  task automatic clearReq();
    @(negedge clk);
    reqValid = '0; reqSpec = '0; reqPort = '0; vaOk = '1;
  endtask

  task automatic setReq(input int i, input int v, input int port, input bit spec);
    reqValid[i*V+v] = 1'b1;
    reqSpec[i*V+v] = spec;
    reqPort[(i*V+v)*PW +: PW] = PW'(port);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < P; i++) begin p1[c][i] = 0; p2[c][i] = 0; end

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset grantVc", 64'(grantVc), 64'd0);
    check("R1 reset xbarSel", 64'(xbarSel), 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R1 after reset xbarSel", 64'(xbarSel), 64'd0);

    // R10: out-of-range port codes are ignored
    clearReq();
    setReq(0, 0, 5, 0);
    setReq(1, 2, 7, 1);
    setReq(2, 1, 6, 0);
    step("R10 bad port");
    check("R10 no grant", 64'(grantVc), 64'd0);

    // R4: one input, four channels to port 1 -> channels rotate 0,1,2,3,0
    clearReq();
    for (int v = 0; v < V; v++) setReq(0, v, 1, 0);
    for (int s = 0; s < 5; s++) begin
      step("R4 vc rotate");
      check("R4 vc order", 64'(grantVc[V-1:0]), 64'(1 << (s % V)));
      check("R2 xbar follows port", 64'(xbarSel[1*P +: P]), 64'd1);
    end

    // R5: five inputs to port 2 -> inputs rotate 0..4,0
    clearReq();
    for (int i = 0; i < P; i++) setReq(i, 0, 2, 0);
    for (int s = 0; s < 6; s++) begin
      step("R5 input rotate");
      check("R5 input order", 64'(xbarSel[2*P +: P]), 64'(1 << (s % P)));
    end

    // R6: non-speculative beats speculative at the same output
    clearReq();
    setReq(0, 1, 3, 0);
    setReq(1, 0, 3, 1);
    step("R6 output merge");
    check("R6 ns wins", 64'(xbarSel[3*P +: P]), 64'b00001);
    check("R6 spec lost", 64'(grantVc[1*V +: V]), 64'd0);

    // R7: speculative dropped when the same input has a ns grant
    clearReq();
    setReq(2, 0, 0, 0);
    setReq(2, 1, 4, 1);
    step("R7 input merge");
    check("R7 ns vc only", 64'(grantVc[2*V +: V]), 64'b0001);
    check("R7 spec output idle", 64'(xbarSel[4*P +: P]), 64'd0);

    // R8: failed VC allocation wastes the grant; retry succeeds
    clearReq();
    setReq(3, 2, 1, 1);
    vaOk[3*V+2] = 1'b0;
    step("R8 va fail");
    check("R8 wasted", 64'(grantVc), 64'd0);
    @(negedge clk);
    vaOk[3*V+2] = 1'b1;
    step("R8 retry");
    check("R8 retry granted", 64'(grantVc[3*V +: V]), 64'b0100);
    check("R8 retry xbar", 64'(xbarSel[1*P +: P]), 64'b01000);

    // R9: spec arbitration after losses — model keeps pointers only for survivors
    clearReq();
    setReq(0, 0, 4, 0);
    setReq(1, 0, 4, 1);
    setReq(2, 0, 4, 1);
    step("R9 spec loses");
    @(negedge clk);
    reqValid[0] = 1'b0;
    step("R9 spec pointer held");
    check("R9 input1 first", 64'(xbarSel[4*P +: P]), 64'b00010);

    // random mix: R2 R3 R6 R7 R8 R9 against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      for (int k = 0; k < NV; k++) begin
        reqValid[k] = ($urandom % 100) < 45;
        reqSpec[k]  = ($urandom % 100) < 40;
        vaOk[k]     = ($urandom % 100) < 75;
        reqPort[k*PW +: PW] = PW'(($urandom % 100) < 5 ? 5 + ($urandom % 3) : $urandom % P);
      end
      step("R9 random");
    end

    finishRun();
  end
endmodule